// File: doc/BRIEF.md
# Strided Address Vector Generator

This unit sits in the execute stage of a vector pipeline and produces the per-element addresses used by strided loads and strided stores; both operations share it unchanged. It receives a scalar base address together with a vector of per-element increments. It returns a vector of absolute addresses. The first active element lands on the base. Each later active element is the previous element's address advanced by the previous element's own increment. The result is therefore an exclusive running sum that is seeded with the base.

Only the lanes below the active vector length are rewritten. Every lane at or above it leaves the block holding the increment value it came in with. The result is registered once per instruction, one cycle after the input strobe, and carries a matching output strobe. All arithmetic wraps at the address width and raises no flag.

At decode, the increment vector is taken from the second register field of the instruction and the base scalar from the first. This is the reverse of ordinary register-register operations. Field decoding and the memory accesses themselves happen outside this unit.

Top module: `stride_addr_gen`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and every lane of `addr_out` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1 and `rst` was 0, and 0 otherwise.
- R3: When `vlen` is at least 1, lane 0 of the registered result equals `base` as presented with the strobe.
- R4: For each lane i with 1 <= i < `vlen`, the result lane i equals result lane i-1 plus input increment lane i-1. The input increment values are used, never the rewritten ones, so negative increments step downward.
- R5: Every lane i with i >= `vlen` carries input increment lane i unchanged. When `vlen` is 0, the whole result equals the increment vector.
- R6: Additions wrap modulo 2^`ADDR_W` and raise no indication. For example, base 0xFFFFFFF0 with increment 0x20 gives 0x00000010 in the next lane.
- R7: In a cycle after `in_valid` was low, `addr_out` keeps its previous value.
- R8: A `vlen` larger than `LANES` computes every lane as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| base | input | ADDR_W | Scalar base address |
| stride | input | LANES x ADDR_W | Per-lane increment vector; lane i is `stride[i]` |
| vlen | input | $clog2(LANES+1) | Number of active lanes |
| out_valid | output | 1 | `addr_out` holds a new result |
| addr_out | output | LANES x ADDR_W | Registered address vector |

## Verification
Running-sum lanes and pass-through lanes meet in the same output word whenever the length lies strictly between 0 and `LANES`. A register result can also be written in the same cycle that the previous one is read out, because instructions arrive back to back. Most random instructions use a partial length and are issued with no idle gap. A prefix-sum model in the bench judges each lane on its own, against the running sum or against the input increment, depending on where that lane sits relative to the length of its own instruction.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int SAG_ADDR_W = 32;
  localparam int SAG_LANES  = 8;

  // A lane takes part in the running sum when its index is below the length.
  function automatic logic lane_active(int unsigned idx, int unsigned len);
    return idx < len;
  endfunction
endpackage

// File: rtl/sag_prefix.sv
module sag_prefix #(
  parameter int W     = 32,
  parameter int LANES = 8
) (
  input  logic [W-1:0]            base,
  input  logic [LANES-1:0][W-1:0] stride,
  output logic [LANES-1:0][W-1:0] sums
);
  // Exclusive running sum seeded with the base; ripple chain of adders.
  assign sums[0] = base;
  for (genvar i = 1; i < LANES; i++) begin : g_step
    assign sums[i] = sums[i-1] + stride[i-1];
  end
endmodule

// File: rtl/sag_lane_sel.sv
module sag_lane_sel #(
  parameter int W     = 32,
  parameter int LANES = 8,
  parameter int LEN_W = 4
) (
  input  logic [LANES-1:0][W-1:0] sums,
  input  logic [LANES-1:0][W-1:0] stride,
  input  logic [LEN_W-1:0]        vlen,
  output logic [LANES-1:0][W-1:0] merged
);
  import sag_pkg::*;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic act;
    assign act       = lane_active(i, 32'(vlen));
    assign merged[i] = act ? sums[i] : stride[i];
  end
endmodule

// File: rtl/sag_out_reg.sv
module sag_out_reg #(
  parameter int W     = 32,
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [LANES-1:0][W-1:0] d,
  output logic [LANES-1:0][W-1:0] q,
  output logic                    vq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      vq <= 1'b0;
    end else begin
      vq <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int ADDR_W = sag_pkg::SAG_ADDR_W,
  parameter int LANES  = sag_pkg::SAG_LANES,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [ADDR_W-1:0]            base,
  input  logic [LANES-1:0][ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]             vlen,
  output logic                         out_valid,
  output logic [LANES-1:0][ADDR_W-1:0] addr_out
);
  logic [LANES-1:0][ADDR_W-1:0] sums;
  logic [LANES-1:0][ADDR_W-1:0] merged;

  sag_prefix #(.W(ADDR_W), .LANES(LANES)) prefix_i (
    .base  (base),
    .stride(stride),
    .sums  (sums)
  );

  sag_lane_sel #(.W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) sel_i (
    .sums  (sums),
    .stride(stride),
    .vlen  (vlen),
    .merged(merged)
  );

  sag_out_reg #(.W(ADDR_W), .LANES(LANES)) oreg_i (
    .clk(clk),
    .rst(rst),
    .en (in_valid),
    .d  (merged),
    .q  (addr_out),
    .vq (out_valid)
  );
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int W     = 32,
  parameter int LANES = 8,
  parameter int LEN_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [W-1:0]            base,
  input logic [LANES-1:0][W-1:0] stride,
  input logic [LEN_W-1:0]        vlen,
  input logic                    out_valid,
  input logic [LANES-1:0][W-1:0] addr_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && addr_out == '0));

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_low_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_lane0_base_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen != '0) |=> addr_out[0] == $past(base));

  if (LANES > 1) begin : g_step1
    assert_lane1_step_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && 32'(vlen) >= 2) |=> addr_out[1] == $past(base) + $past(stride[0]));
  end

  assert_zero_len_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen == '0) |=> addr_out == $past(stride));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(addr_out));
endmodule

bind stride_addr_gen sag_checker #(.W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .stride(stride),
  .vlen(vlen), .out_valid(out_valid), .addr_out(addr_out)
);

// File: tb/stride_addr_gen_tb_top.sv
module stride_addr_gen_tb_top;
  localparam int W     = 32;
  localparam int LANES = 8;
  localparam int LEN_W = $clog2(LANES + 1);
  typedef logic [LANES-1:0][W-1:0] vec_t;
  typedef struct { vec_t v; int len; string tag; } item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [W-1:0]     base = '0;
  vec_t             stride = '0;
  logic [LEN_W-1:0] vlen = '0;
  logic             out_valid;
  vec_t             addr_out;

  stride_addr_gen #(.ADDR_W(W), .LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .stride(stride),
    .vlen(vlen), .out_valid(out_valid), .addr_out(addr_out)
  );

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  vec_t  last_v;
  bit    have_last = 0;
  bit    done = 0;

  function automatic vec_t model(logic [W-1:0] b, vec_t s, int len);
    vec_t r = s;
    logic [W-1:0] acc = b;
    for (int i = 0; i < LANES; i++) begin
      if (i < len) begin
        r[i] = acc;
        acc  = acc + s[i];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] b, vec_t s, int len, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    base     = b;
    stride   = s;
    vlen     = LEN_W'(len);
    sb_q.push_back('{model(b, s, len), len, tag});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard when a result appears.
  always @(posedge clk) begin : mon
    logic pv, pr;
    item_t it;
    string tg;
    pv = in_valid;
    pr = rst;
    #2;
    if (!pr && !done) begin
      check(out_valid == pv, "R2", "out_valid", W'(out_valid), W'(pv));
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "result with empty scoreboard", W'(1), W'(0));
        end else begin
          it = sb_q.pop_front();
          for (int i = 0; i < LANES; i++) begin
            if (it.tag != "") tg = it.tag;
            else if (i >= it.len) tg = "R5";
            else if (i == 0) tg = "R3";
            else tg = "R4";
            check(addr_out[i] == it.v[i], tg, $sformatf("lane %0d", i), addr_out[i], it.v[i]);
          end
          last_v = it.v;
          have_last = 1;
        end
      end else if (have_last) begin
        for (int i = 0; i < LANES; i++)
          check(addr_out[i] == last_v[i], "R7", $sformatf("hold lane %0d", i), addr_out[i], last_v[i]);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    vec_t s;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", W'(out_valid), W'(0));
    check(addr_out == '0, "R1", "addr_out lane0 in reset", addr_out[0], '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < LANES; i++) s[i] = W'(i * 16 + 4);
    send(32'h0000_1000, s, 0, "R5");
    send(32'h0000_2000, s, 1, "");
    send(32'h0000_3000, s, LANES, "");
    send(32'h0000_4000, s, 15, "R8");
    for (int i = 0; i < LANES; i++) s[i] = 32'h0000_0020;
    send(32'hFFFF_FFF0, s, LANES, "R6");
    for (int i = 0; i < LANES; i++) s[i] = -32'sd12 - W'(i);
    send(32'h0000_0100, s, 6, "");
    idle(3);

    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < LANES; i++)
        s[i] = ($urandom_range(0, 3) == 0) ? W'($urandom) : W'($urandom_range(0, 400)) - W'(200);
      send(W'($urandom), s, $urandom_range(0, LANES), "");
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    done = 1;
    check(sb_q.size() == 0, "R2", "scoreboard drained", W'(sb_q.size()), W'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule